// File: doc/BRIEF.md
# Fault Event Queue with Stalled-Transaction Release

This block sits beside an address-translation engine and turns its translation faults into records that software reads out in arrival order. The records live in a local circular buffer. The block writes records and advances the producer index. Software reads them through a pop port, which advances the consumer index. An interrupt line stays high while at least one record is waiting.

A fault can come from a stream that is configured to stall. In that case the block tries to hold the faulting transaction instead of ending it. The transaction is parked in one of a small number of stall slots, and the slot number travels in the record as a tag. Later, software sends a resume command carrying that tag and a retry-or-abort choice. The block then releases the parked transaction on a release port.

A stall fault is held only when both a free slot and queue space exist. Otherwise it is terminated the same way as an ordinary fault. Faults that arrive while the queue is full are lost, and a sticky overflow flag records the loss.

Top module: `stall_evq`

## Requirements
- R1: After reset the queue is empty, `ev_irq`, `ev_overflow`, `ev_valid`, `flt_rsp_valid` and `rel_valid` are 0, and all stall slots are free.
- R2: A fault accepted while the queue holds fewer than DEPTH records is appended as one record laid out as {held bit (MSB), tag (TAG_W bits), stream id (SID_W bits), fault address (ADDR_W bits, LSBs)}. `ev_irq` is 1 from the cycle after the write for as long as any record remains.
- R3: A pop request on a non-empty queue gives `ev_valid`=1 with the oldest record on `ev_data` in the following cycle. Records leave in arrival order. A pop on an empty queue is ignored: `ev_valid` stays 0.
- R4: The queue is full at DEPTH records. A fault arriving while it is full writes no record and sets `ev_overflow`, which stays 1 until reset.
- R5: A stall-mode fault that finds a free slot and queue space is held. In the next cycle `flt_rsp_valid`=1, `flt_rsp_held`=1 and `flt_rsp_tag` is the lowest-numbered free slot. Its record has held bit 1 and that tag.
- R6: Every fault gives `flt_rsp_valid`=1 in the next cycle. A fault that is not held reports `flt_rsp_held`=0 (terminated) with tag 0, and its record (if written) has held bit 0 and tag 0.
- R7: A stall-mode fault arriving while all SLOTS slots are busy is terminated as in R6 rather than held.
- R8: A resume command naming a busy slot frees it. In the next cycle it gives `rel_valid`=1, `rel_tag` equal to the command's tag, and `rel_retry`=1 when `rsm_abort` was 0, or `rel_retry`=0 when `rsm_abort` was 1.
- R9: A resume command naming a free slot is ignored: `rel_valid` stays 0 and slot allocation is unchanged.
- R10: The indices wrap around the buffer so that order and full/empty detection stay correct over any number of passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_valid | input | 1 | A translation fault is presented this cycle |
| flt_sid | input | SID_W | Stream id of the faulting transaction |
| flt_addr | input | ADDR_W | Faulting address |
| flt_stall_mode | input | 1 | The stream is configured to stall on faults |
| rsm_valid | input | 1 | Resume command presented |
| rsm_tag | input | TAG_W | Slot named by the resume command |
| rsm_abort | input | 1 | 1 = abort the held transaction, 0 = retry it |
| ev_pop | input | 1 | Software reads and removes the oldest record |
| ev_valid | output | 1 | `ev_data` holds a popped record this cycle |
| ev_data | output | EV_W | Popped record |
| ev_irq | output | 1 | Queue not empty |
| ev_overflow | output | 1 | Sticky: a fault was lost to a full queue |
| flt_rsp_valid | output | 1 | Outcome of last cycle's fault |
| flt_rsp_held | output | 1 | 1 = held in a slot, 0 = terminated |
| flt_rsp_tag | output | TAG_W | Slot of the held transaction |
| rel_valid | output | 1 | A held transaction is released |
| rel_tag | output | TAG_W | Slot being released |
| rel_retry | output | 1 | 1 = retry, 0 = abort |

## Verification
Every result is due exactly one clock after the edge that samples its cause:
- the fault outcome, the release and the popped record each appear in the next cycle;
- `ev_irq` and `ev_overflow` change one edge after the write or loss.

The bench drives inputs on the falling edge, advances a behavioural queue-and-slot model on the rising edge, and compares all outputs on the next falling edge. Each comparison therefore lands in the cycle the result is due. Directed sequences cover filling and overrunning the queue, exhausting the slots, and resuming an unknown tag. A pseudo-random phase then mixes all inputs while the same per-cycle comparison continues.

// File: rtl/stall_evq_pkg.sv
package stall_evq_pkg;

  // Width of a tag able to name any of n slots (at least one bit).
  function automatic int tag_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Outcome of a fault after admission.
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TERM  = 2'd1,
    FLT_HOLD  = 2'd2
  } flt_outcome_e;

endpackage

// File: rtl/stall_evq_ring.sv
module stall_evq_ring #(
  parameter int DEPTH_LOG2 = 3,
  parameter int EV_W       = 51
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [EV_W-1:0] wr_data,
  input  logic            rd_en,
  output logic            rd_valid,
  output logic [EV_W-1:0] rd_data,
  output logic            full,
  output logic            empty
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DEPTH_LOG2:0]   prod_q, cons_q;
  logic [EV_W-1:0]       store [DEPTH];
  logic                  rd_fire;
  logic [DEPTH_LOG2:0]   fill;

  assign empty   = (prod_q == cons_q);
  assign full    = (prod_q[DEPTH_LOG2] != cons_q[DEPTH_LOG2]) &&
                   (prod_q[DEPTH_LOG2-1:0] == cons_q[DEPTH_LOG2-1:0]);
  assign rd_fire = rd_en && !empty;
  assign fill    = prod_q - cons_q;

  // Storage without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en)
      store[prod_q[DEPTH_LOG2-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_fire)
      rd_data <= store[cons_q[DEPTH_LOG2-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q   <= '0;
      cons_q   <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (wr_en)   prod_q <= prod_q + 1'b1;
      if (rd_fire) cons_q <= cons_q + 1'b1;
    end
  end

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    fill <= (DEPTH_LOG2+1)'(DEPTH)); // R10
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R4
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_valid); // R3

endmodule

// File: rtl/stall_evq_slots.sv
module stall_evq_slots #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  output logic             slot_free,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             rsm_valid,
  input  logic [TAG_W-1:0] rsm_tag,
  input  logic             rsm_abort,
  output logic             rel_valid,
  output logic [TAG_W-1:0] rel_tag,
  output logic             rel_retry
);
  logic [SLOTS-1:0] busy_q;
  logic [SLOTS:0]   lower_busy;
  logic [SLOTS-1:0] first_free;
  logic             rsm_hit;

  // Priority chain: a slot is chosen when it is free and all below are busy.
  assign lower_busy[0] = 1'b1;
  for (genvar s = 0; s < SLOTS; s++) begin : g_chain
    assign first_free[s]   = !busy_q[s] && lower_busy[s];
    assign lower_busy[s+1] = lower_busy[s] && busy_q[s];
  end

  assign slot_free = !lower_busy[SLOTS];

  always_comb begin
    alloc_tag = '0;
    for (int s = 0; s < SLOTS; s++)
      if (first_free[s]) alloc_tag = TAG_W'(s);
  end

  assign rsm_hit = rsm_valid && (int'(rsm_tag) < SLOTS) && busy_q[rsm_tag];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= '0;
      rel_valid <= 1'b0;
      rel_tag   <= '0;
      rel_retry <= 1'b0;
    end else begin
      rel_valid <= rsm_hit;
      if (rsm_hit) begin
        rel_tag   <= rsm_tag;
        rel_retry <= !rsm_abort;
        busy_q[rsm_tag] <= 1'b0;
      end
      if (alloc_en && slot_free)
        busy_q[alloc_tag] <= 1'b1;
    end
  end

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (slot_free && !busy_q[alloc_tag])); // R5
  AST_RELEASED_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> !busy_q[rel_tag]); // R8
  AST_UNKNOWN_TAG_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (rsm_valid && (int'(rsm_tag) < SLOTS) && !busy_q[rsm_tag]) |=> !rel_valid); // R9

endmodule

// File: rtl/stall_evq.sv
module stall_evq
  import stall_evq_pkg::*;
#(
  parameter int SID_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int DEPTH_LOG2 = 3,
  parameter int SLOTS      = 4,
  parameter int TAG_W      = tag_bits(SLOTS),
  parameter int EV_W       = 1 + TAG_W + SID_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_valid,
  input  logic [SID_W-1:0]  flt_sid,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic              flt_stall_mode,
  input  logic              rsm_valid,
  input  logic [TAG_W-1:0]  rsm_tag,
  input  logic              rsm_abort,
  input  logic              ev_pop,
  output logic              ev_valid,
  output logic [EV_W-1:0]   ev_data,
  output logic              ev_irq,
  output logic              ev_overflow,
  output logic              flt_rsp_valid,
  output logic              flt_rsp_held,
  output logic [TAG_W-1:0]  flt_rsp_tag,
  output logic              rel_valid,
  output logic [TAG_W-1:0]  rel_tag,
  output logic              rel_retry
);
  logic             q_full, q_empty;
  logic             slot_free;
  logic [TAG_W-1:0] alloc_tag;
  flt_outcome_e     outcome;
  logic             rec_write;
  logic [TAG_W-1:0] rec_tag;
  logic [EV_W-1:0]  rec_word;

  // Admission: hold needs both a slot and room for the tagged record.
  always_comb begin
    outcome = FLT_NONE;
    if (flt_valid)
      outcome = (flt_stall_mode && slot_free && !q_full) ? FLT_HOLD : FLT_TERM;
  end

  assign rec_write = flt_valid && !q_full;
  assign rec_tag   = (outcome == FLT_HOLD) ? alloc_tag : '0;
  assign rec_word  = {outcome == FLT_HOLD, rec_tag, flt_sid, flt_addr};

  stall_evq_ring #(
    .DEPTH_LOG2 (DEPTH_LOG2),
    .EV_W       (EV_W)
  ) u_ring (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (rec_write),
    .wr_data  (rec_word),
    .rd_en    (ev_pop),
    .rd_valid (ev_valid),
    .rd_data  (ev_data),
    .full     (q_full),
    .empty    (q_empty)
  );

  stall_evq_slots #(
    .SLOTS (SLOTS),
    .TAG_W (TAG_W)
  ) u_slots (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (outcome == FLT_HOLD),
    .slot_free (slot_free),
    .alloc_tag (alloc_tag),
    .rsm_valid (rsm_valid),
    .rsm_tag   (rsm_tag),
    .rsm_abort (rsm_abort),
    .rel_valid (rel_valid),
    .rel_tag   (rel_tag),
    .rel_retry (rel_retry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_rsp_valid <= 1'b0;
      flt_rsp_held  <= 1'b0;
      flt_rsp_tag   <= '0;
      ev_overflow   <= 1'b0;
      ev_irq        <= 1'b0;
    end else begin
      flt_rsp_valid <= (outcome != FLT_NONE);
      flt_rsp_held  <= (outcome == FLT_HOLD);
      flt_rsp_tag   <= rec_tag;
      if (flt_valid && q_full) ev_overflow <= 1'b1;
      // Next-state emptiness: a write always leaves something; a read of the
      // last record (with no write) empties the queue.
      ev_irq <= rec_write || (!q_empty && !(ev_pop && (u_ring.fill == 1)));
    end
  end

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    ev_overflow |=> ev_overflow); // R4
  AST_FULL_SETS_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && q_full) |=> ev_overflow); // R4
  AST_FAULT_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    flt_valid |=> flt_rsp_valid); // R6
  AST_SATURATED_TERMINATES: assert property (@(posedge clk) disable iff (rst)
    (flt_valid && !slot_free) |=> !flt_rsp_held); // R7
  AST_IRQ_TRACKS_QUEUE: assert property (@(posedge clk) disable iff (rst)
    ev_irq == !q_empty); // R2

endmodule

// File: tb/stall_evq_tb.sv
module stall_evq_tb;
  localparam int SID_W = 16, ADDR_W = 32, DEPTH = 8, SLOTS = 4, TAG_W = 2;
  localparam int EV_W = 1 + TAG_W + SID_W + ADDR_W;

  logic clk = 0, rst = 1;
  logic flt_valid = 0, flt_stall_mode = 0, rsm_valid = 0, rsm_abort = 0, ev_pop = 0;
  logic [SID_W-1:0]  flt_sid = '0;
  logic [ADDR_W-1:0] flt_addr = '0;
  logic [TAG_W-1:0]  rsm_tag = '0;
  logic ev_valid, ev_irq, ev_overflow, flt_rsp_valid, flt_rsp_held, rel_valid, rel_retry;
  logic [EV_W-1:0]  ev_data;
  logic [TAG_W-1:0] flt_rsp_tag, rel_tag;

  always #10 clk = ~clk;

  stall_evq u_dut (
    .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_sid(flt_sid), .flt_addr(flt_addr),
    .flt_stall_mode(flt_stall_mode), .rsm_valid(rsm_valid), .rsm_tag(rsm_tag),
    .rsm_abort(rsm_abort), .ev_pop(ev_pop), .ev_valid(ev_valid), .ev_data(ev_data),
    .ev_irq(ev_irq), .ev_overflow(ev_overflow), .flt_rsp_valid(flt_rsp_valid),
    .flt_rsp_held(flt_rsp_held), .flt_rsp_tag(flt_rsp_tag), .rel_valid(rel_valid),
    .rel_tag(rel_tag), .rel_retry(rel_retry)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Behavioural reference model
  logic [EV_W-1:0] mq[$];
  bit              mbusy [SLOTS];
  bit              m_ovf, m_rsp_v, m_rsp_held, m_rel_v, m_rel_retry, m_ev_v;
  logic [TAG_W-1:0] m_rsp_tag, m_rel_tag;
  logic [EV_W-1:0] m_ev;

  always @(posedge clk) begin
    int  cnt0, ff;
    bit  full0, hold;
    m_rsp_v = 0; m_rel_v = 0; m_ev_v = 0; hold = 0; ff = -1;
    if (rst) begin
      mq.delete();
      foreach (mbusy[s]) mbusy[s] = 0;
      m_ovf = 0;
    end else begin
      cnt0 = mq.size();
      full0 = (cnt0 == DEPTH);
      if (ev_pop && cnt0 > 0) begin m_ev = mq.pop_front(); m_ev_v = 1; end
      if (flt_valid) begin
        for (int s = SLOTS-1; s >= 0; s--) if (!mbusy[s]) ff = s;
        hold = flt_stall_mode && (ff >= 0) && !full0;
        m_rsp_v = 1; m_rsp_held = hold; m_rsp_tag = hold ? TAG_W'(ff) : '0;
        if (!full0) mq.push_back({hold, (hold ? TAG_W'(ff) : TAG_W'(0)), flt_sid, flt_addr});
        else m_ovf = 1;
      end
      if (rsm_valid && mbusy[rsm_tag]) begin
        m_rel_v = 1; m_rel_tag = rsm_tag; m_rel_retry = !rsm_abort; mbusy[rsm_tag] = 0;
      end
      if (hold) mbusy[ff] = 1;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(ev_irq == (mq.size() != 0), "R2", "ev_irq", 64'(ev_irq), 64'(mq.size() != 0));
      chk(ev_overflow == m_ovf, "R4", "ev_overflow", 64'(ev_overflow), 64'(m_ovf));
      chk(ev_valid == m_ev_v, "R3", "ev_valid", 64'(ev_valid), 64'(m_ev_v));
      if (m_ev_v) chk(ev_data == m_ev, "R3", "ev_data", 64'(ev_data), 64'(m_ev));
      chk(flt_rsp_valid == m_rsp_v, "R6", "flt_rsp_valid", 64'(flt_rsp_valid), 64'(m_rsp_v));
      if (m_rsp_v) begin
        chk(flt_rsp_held == m_rsp_held, "R5", "flt_rsp_held", 64'(flt_rsp_held), 64'(m_rsp_held));
        chk(flt_rsp_tag == m_rsp_tag, "R5", "flt_rsp_tag", 64'(flt_rsp_tag), 64'(m_rsp_tag));
      end
      chk(rel_valid == m_rel_v, "R8", "rel_valid", 64'(rel_valid), 64'(m_rel_v));
      if (m_rel_v) begin
        chk(rel_tag == m_rel_tag, "R8", "rel_tag", 64'(rel_tag), 64'(m_rel_tag));
        chk(rel_retry == m_rel_retry, "R8", "rel_retry", 64'(rel_retry), 64'(m_rel_retry));
      end
    end
  end

  task automatic fault(input bit stall, input logic [SID_W-1:0] sid, input logic [ADDR_W-1:0] a);
    flt_valid = 1; flt_stall_mode = stall; flt_sid = sid; flt_addr = a;
    @(negedge clk);
    flt_valid = 0; flt_stall_mode = 0;
  endtask

  task automatic resume(input logic [TAG_W-1:0] t, input bit ab);
    rsm_valid = 1; rsm_tag = t; rsm_abort = ab;
    @(negedge clk);
    rsm_valid = 0;
  endtask

  task automatic pop();
    ev_pop = 1;
    @(negedge clk);
    ev_pop = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // r1_ reset state
    chk(!ev_irq && !ev_overflow && !ev_valid && !flt_rsp_valid && !rel_valid, "R1",
        "reset outputs", 64'({ev_irq, ev_overflow, ev_valid, flt_rsp_valid, rel_valid}), 64'd0);

    // R6: terminated faults and their records
    fault(0, 16'h0102, 32'hA000_0000);
    chk(flt_rsp_valid && !flt_rsp_held, "R6", "non-stall outcome", 64'(flt_rsp_held), 64'd0);
    fault(0, 16'h0304, 32'hA000_1000);
    pop();
    chk(ev_data == {1'b0, 2'd0, 16'h0102, 32'hA000_0000}, "R2", "first record",
        64'(ev_data), 64'({1'b0, 2'd0, 16'h0102, 32'hA000_0000}));
    pop();
    pop();
    chk(!ev_valid, "R3", "pop on empty", 64'(ev_valid), 64'd0);

    // R4: fill, overrun, stall fault while full
    for (int i = 0; i < DEPTH; i++) fault(0, 16'(i), 32'(i * 16));
    chk(ev_irq && !ev_overflow, "R4", "full no overflow yet", 64'(ev_overflow), 64'd0);
    fault(0, 16'hDEAD, 32'h1);
    chk(ev_overflow, "R4", "overflow set", 64'(ev_overflow), 64'd1);
    fault(1, 16'hBEEF, 32'h2);
    chk(!flt_rsp_held, "R4", "stall fault when full aborted", 64'(flt_rsp_held), 64'd0);
    for (int i = 0; i < DEPTH; i++) pop();
    chk(!ev_irq && ev_overflow, "R10", "drained, overflow sticky", 64'({ev_irq, ev_overflow}), 64'b01);

    // R5/R7: fill all slots, fifth terminated
    for (int i = 0; i < SLOTS; i++) begin
      fault(1, 16'h0A00 + 16'(i), 32'hB000_0000 + 32'(i));
      chk(flt_rsp_held && flt_rsp_tag == TAG_W'(i), "R5", "held tag", 64'(flt_rsp_tag), 64'(i));
      pop();
    end
    fault(1, 16'h0AFF, 32'hB0FF_0000);
    chk(!flt_rsp_held, "R7", "fifth stall terminated", 64'(flt_rsp_held), 64'd0);
    pop();

    // R8/R9: release, repeat release ignored, slot reuse
    resume(2'd1, 0);
    chk(rel_valid && rel_tag == 2'd1 && rel_retry, "R8", "retry release", 64'({rel_valid, rel_tag, rel_retry}), 64'b1011);
    resume(2'd1, 1);
    chk(!rel_valid, "R9", "unknown tag ignored", 64'(rel_valid), 64'd0);
    fault(1, 16'h0B01, 32'hC000_0000);
    chk(flt_rsp_held && flt_rsp_tag == 2'd1, "R9", "lowest free reused", 64'(flt_rsp_tag), 64'd1);
    pop();
    resume(2'd3, 1);
    chk(rel_valid && rel_tag == 2'd3 && !rel_retry, "R8", "abort release", 64'({rel_valid, rel_tag, rel_retry}), 64'b1110);
    for (int t = 0; t < SLOTS; t++) if (t != 3) resume(TAG_W'(t), t[0]);

    // Mixed pseudo-random traffic, R10 wrap exercised many times
    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      flt_valid = lcg[31]; flt_stall_mode = lcg[30] | lcg[29];
      flt_sid = lcg[27:12]; flt_addr = {lcg[15:0], lcg[31:16]};
      rsm_valid = lcg[11] & lcg[10]; rsm_tag = lcg[9:8]; rsm_abort = lcg[7];
      ev_pop = lcg[6] | (lcg[5] & lcg[4]);
      @(negedge clk);
    end
    flt_valid = 0; rsm_valid = 0; ev_pop = 0;
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule